// File: doc/BRIEF.md
# Decimal Prefix-Carry Adder

This block adds two packed binary-coded-decimal operands plus a one-bit carry-in. It returns a packed decimal sum of the same width and a decimal carry-out. It is purely combinational. The number of digits is a parameter, and the default is 16 digits, which is 64 bits per operand. Digit 0 is the least significant digit and sits in bits [3:0]. Every operand digit is assumed to lie in the range 0 to 9.

The carries are not passed digit to digit. Each digit position looks at the plain binary sum of its two digits, taken without any incoming carry:

- A sum of ten or more means the position creates a carry by itself (generate).
- A sum of exactly nine means the position passes an incoming carry straight on (propagate).

These per-digit pairs go into a logarithmic prefix tree, which returns the decimal carry into every digit at once. The external carry-in is folded into the pair of digit 0. Each digit then uses its own carry in a single-digit decimal adder. That adder does a binary add and then applies a select-based correction of six.

The carry-out of the whole adder is the carry leaving the most significant digit. The total depth grows with the logarithm of the digit count plus a constant.

Top module: `bcd_prefix_adder`

## Requirements
- R1: Every 4-bit output digit lies in the range 0 to 9 whenever all operand digits are valid.
- R2: The pair {cout, sum} equals the decimal value of opa + opb + cin, read as a 17-digit decimal number.
- R3: A digit pair whose binary sum is 10 or more sends a carry of 1 into the next digit regardless of the carry below it, and its own sum digit is (pair sum + incoming carry − 10).
- R4: When both operands are all nines and cin is 0, the sum is all nines except digit 0, which is 8, and cout is 1.
- R5: When opa is all nines, opb is zero and cin is 1, the sum is all zeros and cout is 1, because the carry passes through every propagating digit.
- R6: cout equals the carry leaving the most significant digit (digit NDIG-1) and does not depend on lower digits in any other way.
- R7: Digit 0 occupies bits [3:0], and cin is added at digit 0 only.
- R8: A run of digits whose pair sum is 9 produces nines and passes no carry when the carry entering the run is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | NDIG*4 | First packed decimal operand, digit 0 in bits [3:0] |
| opb | input | NDIG*4 | Second packed decimal operand |
| cin | input | 1 | Carry into digit 0 |
| sum | output | NDIG*4 | Packed decimal sum |
| cout | output | 1 | Carry out of the most significant digit |

## Verification
The bench goes after long propagate chains, because a prefix tree that pairs the wrong spans would drop a carry partway along a run of nines.

It targets three cases in particular:

- All-nines operands with carry-in 1, and all-nines plus all-nines with carry-in 0. A wrong tree would show up here as a wrong digit or a missing cout.
- A carry-in that only affects digit 0. A design that injects the carry at the wrong place would fail this case.
- A run of nines with no carry entering it. A design that treats propagate as generate would wrongly bump that run.

Random valid operands are then compared against a digit-by-digit ripple reference model.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    // Combine a high span with the adjacent lower span.
    function automatic pg_t pg_merge(pg_t hi, pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // True when a 5-bit binary digit sum is ten or more.
    function automatic logic over_nine(logic [4:0] s);
        return s[4] | (s[3] & (s[2] | s[1]));
    endfunction

    // Low four bits of (s + 6), written with selects instead of a second adder.
    function automatic digit_t add_six(digit_t s);
        digit_t r;
        r[0] = s[0];
        r[1] = ~s[1];
        r[2] = ~(s[2] ^ s[1]);
        r[3] = s[3] ^ (s[2] | s[1]);
        return r;
    endfunction

endpackage

// File: rtl/bcd_digit_pg.sv
module bcd_digit_pg
    import bcd_add_pkg::*;
(
    input  digit_t da,
    input  digit_t db,
    output pg_t    pg
);
    logic [4:0] raw;

    always_comb begin
        raw  = {1'b0, da} + {1'b0, db};
        pg.g = over_nine(raw);
        pg.p = (raw == 5'd9);
    end

    // R3: a digit pair cannot both generate and propagate.
    always_comb begin
        if (!$isunknown({da, db}))
            a_r3_pg_exclusive: assert (!(pg.g && pg.p))
                else $error("R3 pg both set");
    end
endmodule

// File: rtl/bcd_prefix_net.sv
module bcd_prefix_net
    import bcd_add_pkg::*;
#(
    parameter int N = 16
) (
    input  pg_t          leaf [N],
    output logic [N-1:0] grp_g
);
    localparam int LV = (N > 1) ? $clog2(N) : 1;

    pg_t lvl [LV+1][N];

    always_comb begin
        for (int i = 0; i < N; i++) lvl[0][i] = leaf[i];
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < N; i++) begin
                if (((i >> l) & 1) == 1)
                    lvl[l+1][i] = pg_merge(lvl[l][i], lvl[l][((i >> l) << l) - 1]);
                else
                    lvl[l+1][i] = lvl[l][i];
            end
        end
        for (int i = 0; i < N; i++) grp_g[i] = lvl[LV][i].g;
    end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_add_pkg::*;
(
    input  digit_t da,
    input  digit_t db,
    input  logic   ci,
    output digit_t ds,
    output logic   co
);
    logic [4:0] raw;

    always_comb begin
        raw = {1'b0, da} + {1'b0, db} + {4'd0, ci};
        co  = over_nine(raw);
        ds  = co ? add_six(raw[3:0]) : raw[3:0];
    end

    // R1: a valid-input digit never produces a sum digit above nine.
    always_comb begin
        if (!$isunknown({da, db, ci}) && da <= 4'd9 && db <= 4'd9)
            a_r1_digit_valid: assert (ds <= 4'd9)
                else $error("R1 digit out of range");
    end
endmodule

// File: rtl/bcd_prefix_adder.sv
module bcd_prefix_adder
    import bcd_add_pkg::*;
#(
    parameter int NDIG = 16
) (
    input  logic [NDIG*4-1:0] opa,
    input  logic [NDIG*4-1:0] opb,
    input  logic              cin,
    output logic [NDIG*4-1:0] sum,
    output logic              cout
);
    pg_t             raw_pg [NDIG];
    pg_t             leaf   [NDIG];
    logic [NDIG-1:0] grp_g;
    logic [NDIG:0]   dcar;
    logic [NDIG-1:0] dco;
    logic [NDIG-1:0] all_p;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        bcd_digit_pg u_pg (
            .da (opa[4*i +: 4]),
            .db (opb[4*i +: 4]),
            .pg (raw_pg[i])
        );

        if (i == 0) begin : g_fold
            // The external carry-in is folded into the pair of digit 0.
            assign leaf[i].g = raw_pg[i].g | (raw_pg[i].p & cin);
            assign leaf[i].p = raw_pg[i].p;
        end else begin : g_pass
            assign leaf[i] = raw_pg[i];
        end

        assign all_p[i] = raw_pg[i].p;

        bcd_digit_add u_add (
            .da (opa[4*i +: 4]),
            .db (opb[4*i +: 4]),
            .ci (dcar[i]),
            .ds (sum[4*i +: 4]),
            .co (dco[i])
        );
    end

    bcd_prefix_net #(.N(NDIG)) u_tree (
        .leaf  (leaf),
        .grp_g (grp_g)
    );

    assign dcar = {grp_g, cin};
    assign cout = grp_g[NDIG-1];

    // R2: the tree carry into each digit matches the local carry of the digit below.
    // R6: cout matches the carry leaving the most significant digit.
    // R5: when every digit propagates, cin passes straight through to cout.
    always_comb begin
        if (!$isunknown({opa, opb, cin})) begin
            a_r2_carry_agree: assert (dco == grp_g)
                else $error("R2 carry mismatch");
            a_r6_cout_msd: assert (cout == dco[NDIG-1])
                else $error("R6 cout mismatch");
            if (&all_p)
                a_r5_full_prop: assert (cout == cin)
                    else $error("R5 chain broken");
        end
    end
endmodule

// File: tb/tb_bcd_prefix_adder.sv
`timescale 1ns/1ps
module tb_bcd_prefix_adder;
    localparam int ND = 16;
    localparam int W  = ND * 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    bcd_prefix_adder #(.NDIG(ND)) dut (
        .opa  (opa),
        .opb  (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [W-1:0] esum;
        logic         ecout;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done   = 0;

    // Reference model: digit-by-digit decimal ripple.
    function automatic void ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic c, output logic [W-1:0] s,
                                    output logic co);
        int car = int'(c);
        for (int i = 0; i < ND; i++) begin
            int t = int'(a[4*i +: 4]) + int'(b[4*i +: 4]) + car;
            car = (t >= 10) ? 1 : 0;
            s[4*i +: 4] = 4'(t % 10);
        end
        co = car[0];
    endfunction

    function automatic logic [W-1:0] rep(input logic [3:0] d);
        logic [W-1:0] r;
        for (int i = 0; i < ND; i++) r[4*i +: 4] = d;
        return r;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        opa = a;
        opb = b;
        cin = c;
        ref_add(a, b, c, it.esum, it.ecout);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: one expected item per cycle, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            bit    bad_digit;
            it = sb_q.pop_front();
            n_chk++;
            if (sum !== it.esum || cout !== it.ecout) begin
                n_fail++;
                $display("FAIL %s: got sum=%h cout=%b expected sum=%h cout=%b",
                         it.tag, sum, cout, it.esum, it.ecout);
            end
            bad_digit = 0;
            for (int i = 0; i < ND; i++)
                if (sum[4*i +: 4] > 4'd9) bad_digit = 1;
            n_chk++;
            if (bad_digit) begin
                n_fail++;
                $display("FAIL R1 digit range: got sum=%h expected all digits <= 9", sum);
            end
        end
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        drive('0, '0, 1'b0, "R2 zero operands");
        drive(rep(4'd9), rep(4'd9), 1'b0, "R4 all nines cin0");
        drive(rep(4'd9), rep(4'd9), 1'b1, "R4 all nines cin1");
        drive(rep(4'd9), '0, 1'b1, "R5 full propagate chain");
        drive(rep(4'd9), '0, 1'b0, "R8 nines without carry");
        drive({{(W-16){1'b0}}, 16'h0999}, '0, 1'b0, "R8 run of nines stays");
        drive({{(W-16){1'b0}}, 16'h0999}, '0, 1'b1, "R8 run of nines with carry");
        drive({{(W-4){1'b0}}, 4'h5}, {{(W-4){1'b0}}, 4'h5}, 1'b0, "R3 generate digit0");
        drive({{(W-8){1'b0}}, 8'h45}, {{(W-8){1'b0}}, 8'h48}, 1'b1, "R3 generate mid");
        drive('0, '0, 1'b1, "R7 cin lands in bits 3:0");
        drive({{(W-4){1'b0}}, 4'h1}, '0, 1'b0, "R7 digit0 position");
        drive({4'h9, {(W-4){1'b0}}}, {4'h1, {(W-4){1'b0}}}, 1'b0, "R6 msd carry");
        drive({4'h4, {(W-4){1'b1}} & rep(4'd9)}, {4'h4, {(W-4){1'b0}}}, 1'b1, "R6 msd no carry");

        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra, rb;
            for (int i = 0; i < ND; i++) begin
                ra[4*i +: 4] = 4'($urandom % 10);
                rb[4*i +: 4] = 4'($urandom % 10);
            end
            drive(ra, rb, 1'($urandom % 2), "R2 random operands");
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule